// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands and reports whether the first is greater than, equal to, or less than the second. It has no clock and no reset. The result settles a ripple delay after the operands change.

The compare is built from one kind of 1-bit cell. Each cell looks at one bit of each operand and at a three-wire flag triple from the cell one place lower. The triple is one-hot: greater, equal or less.
- If the two bits differ, the cell drives its own verdict.
- If the two bits match, the cell passes the incoming triple straight through.

Cells are grouped into fixed-width stages. Each stage has the same triple in and out as a single cell. The stages are then chained from the least significant end to the most significant end.

The chain is seeded at its lowest end with the "equal" flag, so identical operands report equality. The default configuration is 12 bits made of three 4-bit stages. The total width must be a whole multiple of the stage width.

Top module: `mag_cmp_chain`

## Requirements
- R1: When operand A is greater than operand B (unsigned), gt_o=1, eq_o=0 and lt_o=0.
- R2: When A equals B, eq_o=1, gt_o=0 and lt_o=0.
- R3: When A is less than B (unsigned), lt_o=1, gt_o=0 and eq_o=0.
- R4: For every operand pair, exactly one of gt_o, eq_o, lt_o is 1.
- R5: A cell whose A bit is 1 and B bit is 0 drives the triple greater=1, equal=0, less=0, whatever its incoming triple is.
- R6: A cell whose A bit is 0 and B bit is 1 drives greater=0, equal=0, less=1, whatever its incoming triple is.
- R7: A cell whose A and B bits match copies its incoming greater, equal and less flags to its outputs unchanged. A stage whose operand slices match does the same.
- R8: The most significant differing bit position alone decides the result. Two operands that differ only in bit 0 are ordered by bit 0. Two operands that differ in the top bit are ordered by the top bit, whatever the lower bits hold.
- R9: The lowest cell of the whole chain receives the triple greater=0, equal=1, less=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | TOTAL_W (12) | First unsigned operand |
| b_i | input | TOTAL_W (12) | Second unsigned operand |
| gt_o | output | 1 | A is greater than B |
| eq_o | output | 1 | A equals B |
| lt_o | output | 1 | A is less than B |

## Verification
The low byte of both operands is swept over all 65,536 combinations while the upper nibble is held equal. This exercises the lowest two stages in every verdict and shows that the top stage passes a matching slice's triple through unchanged.

Directed pairs that differ only in bit 0 separate a working seed and pass-through path from a broken one. Pairs that differ in the top bit, with opposite lower bits, show that the high cell overrides everything beneath it. Equal pairs at all-zero, all-ones and arbitrary values confirm the equal seed reaches the output. Random full-width pairs then cover differences that span stage boundaries.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    // One-hot compare verdict carried along the cascade.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_flags_t;

    // Seed applied at the least significant end of the chain.
    localparam cmp_flags_t SEED_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/mag_cmp_cell.sv
module mag_cmp_cell
    import mag_cmp_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  cmp_flags_t from_low,
    output cmp_flags_t to_high
);

    logic bits_match;

    always_comb begin
        bits_match  = ~(a_bit ^ b_bit);
        to_high.gt  = (a_bit & ~b_bit) | (bits_match & from_low.gt);
        to_high.eq  = bits_match & from_low.eq;
        to_high.lt  = (~a_bit & b_bit) | (bits_match & from_low.lt);
    end

    always_comb begin
        if (a_bit && !b_bit) begin
            AST_CELL_A_WINS: assert (to_high == '{gt: 1'b1, eq: 1'b0, lt: 1'b0})
                else $error("cell A-wins verdict wrong"); // R5
        end
        if (!a_bit && b_bit) begin
            AST_CELL_B_WINS: assert (to_high == '{gt: 1'b0, eq: 1'b0, lt: 1'b1})
                else $error("cell B-wins verdict wrong"); // R6
        end
        if (a_bit == b_bit) begin
            AST_CELL_PASS: assert (to_high == from_low)
                else $error("cell did not pass cascade through"); // R7
        end
        if ($onehot(from_low)) begin
            AST_CELL_ONEHOT: assert ($onehot(to_high))
                else $error("cell broke one-hot cascade"); // R4
        end
    end

endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
    import mag_cmp_pkg::*;
#(
    parameter int STAGE_W = 4
) (
    input  logic [STAGE_W-1:0] a_slice,
    input  logic [STAGE_W-1:0] b_slice,
    input  cmp_flags_t         from_low,
    output cmp_flags_t         to_high
);

    // link[i] feeds cell i; link[STAGE_W] is the stage verdict.
    cmp_flags_t link [STAGE_W+1];

    assign link[0] = from_low;

    for (genvar i = 0; i < STAGE_W; i++) begin : g_cell
        mag_cmp_cell u_cell (
            .a_bit    (a_slice[i]),
            .b_bit    (b_slice[i]),
            .from_low (link[i]),
            .to_high  (link[i+1])
        );
    end

    assign to_high = link[STAGE_W];

    always_comb begin
        if (a_slice != b_slice) begin
            AST_STAGE_ORDER: assert (to_high.gt == (a_slice > b_slice) &&
                                     to_high.lt == (a_slice < b_slice) &&
                                     !to_high.eq)
                else $error("stage ordering wrong"); // R8
        end else begin
            AST_STAGE_PASS: assert (to_high == from_low)
                else $error("stage did not pass cascade through"); // R7
        end
    end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int TOTAL_W = 12,
    parameter int STAGE_W = 4
) (
    input  logic [TOTAL_W-1:0] a_i,
    input  logic [TOTAL_W-1:0] b_i,
    output logic               gt_o,
    output logic               eq_o,
    output logic               lt_o
);

    localparam int N_STAGES = TOTAL_W / STAGE_W;

    if (TOTAL_W % STAGE_W != 0) begin : g_bad_width
        $error("TOTAL_W must be a multiple of STAGE_W");
    end

    cmp_flags_t hop [N_STAGES+1];

    assign hop[0] = SEED_EQUAL;

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        mag_cmp_stage #(.STAGE_W(STAGE_W)) u_stage (
            .a_slice  (a_i[s*STAGE_W +: STAGE_W]),
            .b_slice  (b_i[s*STAGE_W +: STAGE_W]),
            .from_low (hop[s]),
            .to_high  (hop[s+1])
        );
    end

    assign gt_o = hop[N_STAGES].gt;
    assign eq_o = hop[N_STAGES].eq;
    assign lt_o = hop[N_STAGES].lt;

    always_comb begin
        AST_SEED_EQUAL: assert (hop[0].eq && !hop[0].gt && !hop[0].lt)
            else $error("chain seed not equal"); // R9
        AST_ONE_VERDICT: assert ($countones({gt_o, eq_o, lt_o}) == 1)
            else $error("verdict not one-hot"); // R4
        AST_GREATER: assert (gt_o == (a_i > b_i))
            else $error("greater flag wrong"); // R1
        AST_EQUAL: assert (eq_o == (a_i == b_i))
            else $error("equal flag wrong"); // R2
        AST_LESS: assert (lt_o == (a_i < b_i))
            else $error("less flag wrong"); // R3
    end

endmodule

// File: tb/tb_mag_cmp_chain.sv
module tb_mag_cmp_chain;

    localparam int CLK_P = 10;
    localparam int W     = 12;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic         gt, eq, lt;
    int           total = 0;
    int           bad   = 0;
    bit           done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mag_cmp_chain #(.TOTAL_W(W), .STAGE_W(4)) dut (
        .a_i  (a),
        .b_i  (b),
        .gt_o (gt),
        .eq_o (eq),
        .lt_o (lt)
    );

    task automatic check_pair(input logic [W-1:0] va, input logic [W-1:0] vb,
                              input string req);
        logic [2:0] exp_v, got_v;
        a = va;
        b = vb;
        @(negedge clk);
        exp_v = {va > vb, va == vb, va < vb};
        got_v = {gt, eq, lt};
        total++;
        if (got_v !== exp_v || $countones(got_v) != 1) begin
            bad++;
            $display("FAIL %s a=%03h b=%03h got gt/eq/lt=%b expected=%b",
                     req, va, vb, got_v, exp_v);
        end
    endtask

    initial begin
        a = '0;
        b = '0;
        @(negedge clk);
        // Reset-like starting point: zero operands give equal (R2, R9)
        check_pair(12'h000, 12'h000, "R9 seed/R2 zero equal");
        check_pair(12'hFFF, 12'hFFF, "R2 all-ones equal");
        check_pair(12'h5A3, 12'h5A3, "R2 equal");
        // LSB-only differences: R8, R7 pass-through
        check_pair(12'h001, 12'h000, "R8 LSB R1");
        check_pair(12'h000, 12'h001, "R8 LSB R3");
        check_pair(12'hABD, 12'hABC, "R8 LSB R7 pass");
        check_pair(12'hABC, 12'hABD, "R8 LSB R7 pass");
        // MSB differs with opposite lower bits: R5, R6
        check_pair(12'h800, 12'h7FF, "R5 MSB wins R1");
        check_pair(12'h7FF, 12'h800, "R6 MSB wins R3");
        check_pair(12'hFFF, 12'h000, "R5 R1 extreme");
        check_pair(12'h000, 12'hFFF, "R6 R3 extreme");
        // Stage-boundary differences
        check_pair(12'h010, 12'h00F, "R8 stage boundary R1");
        check_pair(12'h0F0, 12'h100, "R8 stage boundary R3");
        // Exhaustive low byte sweep, upper nibble equal (R1 R2 R3 R4 R7)
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                logic [3:0] hi;
                hi = 4'(i ^ j);
                check_pair({hi, 8'(i)}, {hi, 8'(j)}, "R4 sweep R1/R2/R3");
            end
        end
        // Random full width pairs (R4, R8)
        for (int k = 0; k < 20000; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (k % 8 == 0) ? ra : W'($urandom);
            check_pair(ra, rb, "R4 R8 random");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule